// File: doc/BRIEF.md
# Partitioned Element Byte Swapper

This block converts a packed 64-bit word between big-endian and little-endian byte order. The word may hold vector elements of 8, 16, 32 or 64 bits, and several sizes can share one word. The word is cut into eight byte lanes. Each lane has its own four-way selector and picks its source byte from inside its own element. Bytes are reversed within each element and never cross an element boundary, so the order of the elements in the word does not change.

Each byte lane carries a 2-bit size code that names the element it belongs to. A legality checker confirms that every element is naturally aligned and that all lanes of one element carry the same code. When the codes describe an impossible layout, the block raises an error flag and passes the word through unswapped. The result, the valid flag and the error flag appear one clock after the input.

Top module: `lane_byte_swapper`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `out_err` and `out_data` are all cleared to zero, whatever the other inputs are.
- R2: `out_valid` at a rising edge equals the `in_valid` sampled at that edge, so it is seen one cycle after the input.
- R3: When `swap_en` is low, a valid word appears on `out_data` unchanged, whatever the size codes are.
- R4: Lane i (byte i is bits 8i+7:8i) takes its size code from `in_size[2i+1:2i]`. The codes are 00 for 8-bit, 01 for 16-bit, 10 for 32-bit and 11 for 64-bit. With `swap_en` high and a legal layout, output byte i equals input byte (i XOR m), where m is 0, 1, 3 or 7 for those four codes.
- R5: Elements of different sizes can share one word. Each element is reversed inside its own bytes and keeps its position in the word.
- R6: A layout is illegal when an element of 2^c bytes does not start at a multiple of 2^c, or when its lanes carry different codes. A valid illegal layout sets `out_err` and passes the data through unswapped.
- R7: `out_err` is set only together with `out_valid`. It reports the layout whatever the level of `swap_en`.
- R8: Passing a result through the block a second time with the same size codes and `swap_en` high returns the original word.
- R9: While `in_valid` is low, `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 64 | Packed input word, byte 0 in the low bits |
| in_size | input | 16 | Two-bit element-size code for each byte lane |
| swap_en | input | 1 | High to reverse bytes within each element |
| out_valid | output | 1 | Registered strobe |
| out_data | output | 64 | Registered result word |
| out_err | output | 1 | Registered flag for an illegal size layout |

## Verification
The assertions assume that `in_valid`, `swap_en`, `in_size` and `in_data` hold known values from the first cycle after reset, and that reset is held high for at least one rising edge before it falls. The bench meets this by driving every input to a defined value at time zero, holding reset for several cycles, and changing inputs only on falling edges. Random legal layouts are built from a tree of element choices, so the round-trip check never produces a misaligned element. Illegal layouts come only from the directed error scenarios.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

   localparam int SIZE_CODE_W = 2;

   typedef enum logic [SIZE_CODE_W-1:0] {
      ELEM_B8  = 2'b00,
      ELEM_B16 = 2'b01,
      ELEM_B32 = 2'b10,
      ELEM_B64 = 2'b11
   } elem_size_e;

   // number of byte lanes an element of this code spans
   function automatic int elem_lanes(input logic [SIZE_CODE_W-1:0] code);
      return 1 << int'(code);
   endfunction

endpackage

// File: rtl/lbs_legality.sv
module lbs_legality
   import lbs_pkg::*;
#(
   parameter int LANES = 8
) (
   input  logic [SIZE_CODE_W*LANES-1:0] size_codes,
   output logic                         misfit
);

   localparam int CODES_W = SIZE_CODE_W*LANES;

   initial begin
      if (CODES_W != SIZE_CODE_W*LANES) $error("code vector width mismatch");
   end

   // A lane is consistent when every lane in its aligned group shares its code.
   always_comb begin
      misfit = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         int n;
         int base_i;
         n = elem_lanes(size_codes[SIZE_CODE_W*i +: SIZE_CODE_W]);
         base_i = i & ~(n - 1);
         if (n > LANES) begin
            misfit = 1'b1;
         end else begin
            for (int k = 0; k < LANES; k++) begin
               if (((k & ~(n - 1)) == base_i) &&
                   (size_codes[SIZE_CODE_W*k +: SIZE_CODE_W] !=
                    size_codes[SIZE_CODE_W*i +: SIZE_CODE_W]))
                  misfit = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/lbs_lane_mux.sv
module lbs_lane_mux
   import lbs_pkg::*;
#(
   parameter int LANE   = 0,
   parameter int LANES  = 8,
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W*LANES-1:0] word,
   input  logic [SIZE_CODE_W-1:0]  sel,
   output logic [BYTE_W-1:0]       lane_out
);

   // source lanes; a source outside the word falls back to the own lane
   localparam int SRC_B16 = ((LANE ^ 1) < LANES) ? (LANE ^ 1) : LANE;
   localparam int SRC_B32 = ((LANE ^ 3) < LANES) ? (LANE ^ 3) : LANE;
   localparam int SRC_B64 = ((LANE ^ 7) < LANES) ? (LANE ^ 7) : LANE;

   always_comb begin
      unique case (elem_size_e'(sel))
         ELEM_B16: lane_out = word[BYTE_W*SRC_B16 +: BYTE_W];
         ELEM_B32: lane_out = word[BYTE_W*SRC_B32 +: BYTE_W];
         ELEM_B64: lane_out = word[BYTE_W*SRC_B64 +: BYTE_W];
         default:  lane_out = word[BYTE_W*LANE +: BYTE_W];
      endcase
   end

endmodule

// File: rtl/lane_byte_swapper.sv
module lane_byte_swapper
   import lbs_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int BYTE_W = 8
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          in_valid,
   input  logic [LANES*BYTE_W-1:0]       in_data,
   input  logic [SIZE_CODE_W*LANES-1:0]  in_size,
   input  logic                          swap_en,
   output logic                          out_valid,
   output logic [LANES*BYTE_W-1:0]       out_data,
   output logic                          out_err
);

   localparam int WORD_W = LANES*BYTE_W;
   localparam int CODE_W = SIZE_CODE_W*LANES;

   generate
      if (LANES < 1 || LANES > 8 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("LANES must be a power of two from 1 to 8");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("BYTE_W must be positive");
      end
   endgenerate

   logic              misfit;
   logic [WORD_W-1:0] swapped;

   lbs_legality #(.LANES(LANES)) i_legal (
      .size_codes (in_size),
      .misfit     (misfit)
   );

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         logic [SIZE_CODE_W-1:0] lane_sel;
         assign lane_sel = (swap_en && !misfit) ? in_size[SIZE_CODE_W*gi +: SIZE_CODE_W]
                                                : SIZE_CODE_W'(ELEM_B8);
         lbs_lane_mux #(.LANE(gi), .LANES(LANES), .BYTE_W(BYTE_W)) i_mux (
            .word     (in_data),
            .sel      (lane_sel),
            .lane_out (swapped[BYTE_W*gi +: BYTE_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         out_err   <= in_valid & misfit;
         if (in_valid) out_data <= swapped;
      end
   end

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   assert_err_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
      out_err |-> out_valid);
   assert_misfit_passthrough_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && misfit) |=> (out_err && out_data == $past(in_data)));
   assert_swap_off_passthrough_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !swap_en) |=> (out_data == $past(in_data)));
   assert_bytes_only_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_size == '0) |=> (out_data == $past(in_data)));
   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_data));

endmodule

// File: tb/test_lane_byte_swapper.sv
`timescale 1ns/1ps
module test_lane_byte_swapper;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic [15:0] in_size = '0;
   logic        swap_en = 1'b0;
   logic        out_valid;
   logic [63:0] out_data;
   logic        out_err;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lane_byte_swapper i_lane_byte_swapper (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_size(in_size), .swap_en(swap_en), .out_valid(out_valid),
      .out_data(out_data), .out_err(out_err)
   );

   function automatic bit layout_bad(input logic [15:0] sz);
      int p = 0;
      while (p < 8) begin
         int c = int'(sz[2*p +: 2]);
         int n = 1 << c;
         if ((p % n) != 0 || p + n > 8) return 1'b1;
         for (int k = p; k < p + n; k++)
            if (int'(sz[2*k +: 2]) != c) return 1'b1;
         p += n;
      end
      return 1'b0;
   endfunction

   function automatic logic [63:0] model(input logic [63:0] d, input logic [15:0] sz,
                                         input bit en);
      logic [63:0] r;
      if (!en || layout_bad(sz)) return d;
      for (int i = 0; i < 8; i++) begin
         int m = (1 << int'(sz[2*i +: 2])) - 1;
         r[8*i +: 8] = d[8*(i ^ m) +: 8];
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drive one word and sample the registered result one cycle later
   task automatic apply(input logic [63:0] d, input logic [15:0] sz, input bit en,
                        input bit v);
      @(negedge clk);
      in_data = d; in_size = sz; swap_en = en; in_valid = v;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_word(input logic [63:0] d, input logic [15:0] sz, input bit en,
                              input string req);
      logic [63:0] e;
      e = model(d, sz, en);
      apply(d, sz, en, 1'b1);
      check(out_data == e, req, "data", out_data, e);
      check(out_valid == 1'b1, req, "valid", 64'(out_valid), 64'd1);
      check(out_err == layout_bad(sz), req, "err", 64'(out_err), 64'(layout_bad(sz)));
   endtask

   task automatic t_reset_r1();
      @(negedge clk);
      in_valid = 1'b1; in_data = 64'hFFEE_DDCC_BBAA_9988; in_size = 16'h0004;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "valid in reset", 64'(out_valid), 64'd0);
      check(out_err == 1'b0, "R1", "err in reset", 64'(out_err), 64'd0);
      check(out_data == '0, "R1", "data in reset", out_data, 64'd0);
      in_valid = 1'b0;
      rst = 1'b0;
   endtask

   task automatic t_swap_off_r3();
      expect_word(64'h0011_2233_4455_6677, 16'hFFFF, 1'b0, "R3");
      expect_word(64'h8899_AABB_CCDD_EEFF, 16'hAA55, 1'b0, "R3");
   endtask

   task automatic t_uniform_r4();
      logic [63:0] d = 64'h0706_0504_0302_0100;
      expect_word(d, 16'h0000, 1'b1, "R4");
      check(out_data == 64'h0706_0504_0302_0100, "R4", "8-bit", out_data, 64'h0706050403020100);
      expect_word(d, 16'h5555, 1'b1, "R4");
      check(out_data == 64'h0607_0405_0203_0001, "R4", "16-bit", out_data, 64'h0607040502030001);
      expect_word(d, 16'hAAAA, 1'b1, "R4");
      check(out_data == 64'h0405_0607_0001_0203, "R4", "32-bit", out_data, 64'h0405060700010203);
      expect_word(d, 16'hFFFF, 1'b1, "R4");
      check(out_data == 64'h0001_0203_0405_0607, "R4", "64-bit", out_data, 64'h0001020304050607);
   endtask

   task automatic t_mixed_r5();
      // lanes 0,1: 8-bit; lanes 2-3: 16-bit; lanes 4-7: 32-bit
      expect_word(64'h0706_0504_0302_0100, 16'hAA50, 1'b1, "R5");
      check(out_data == 64'h0405_0607_0203_0100, "R5", "mixed", out_data, 64'h0405060702030100);
      // lanes 0-3: 32-bit; lanes 4,5: 16-bit; lanes 6,7: 8-bit
      expect_word(64'h1716_1514_1312_1110, 16'h05AA, 1'b1, "R5");
   endtask

   task automatic t_illegal_r6_r7();
      // 32-bit code on lanes 2-5, 8-bit elsewhere: misaligned
      expect_word(64'hA7A6_A5A4_A3A2_A1A0, 16'h0AA0, 1'b1, "R6");
      check(out_err == 1'b1, "R6", "misaligned flag", 64'(out_err), 64'd1);
      // mismatched codes inside lanes 0-1
      expect_word(64'hB7B6_B5B4_B3B2_B1B0, 16'h0004, 1'b1, "R6");
      check(out_data == 64'hB7B6_B5B4_B3B2_B1B0, "R6", "passthrough", out_data,
            64'hB7B6B5B4B3B2B1B0);
      // error reported with swap off
      expect_word(64'h1, 16'h0004, 1'b0, "R7");
      check(out_err == 1'b1, "R7", "err swap off", 64'(out_err), 64'd1);
      // no error without valid
      apply(64'h2, 16'h0004, 1'b1, 1'b0);
      check(out_err == 1'b0, "R7", "err without valid", 64'(out_err), 64'd0);
   endtask

   task automatic t_hold_r9_r2();
      expect_word(64'hC0FF_EE00_1234_5678, 16'hFFFF, 1'b1, "R9");
      apply(64'h0, 16'h0000, 1'b1, 1'b0);
      check(out_valid == 1'b0, "R2", "valid low", 64'(out_valid), 64'd0);
      check(out_data == 64'h7856_3412_00EE_FFC0, "R9", "held data", out_data,
            64'h7856341200EEFFC0);
   endtask

   function automatic logic [15:0] rand_layout();
      logic [15:0] s = '0;
      if ($urandom % 4 == 0) return 16'hFFFF;
      for (int h = 0; h < 2; h++) begin
         if ($urandom % 2 == 0) s[8*h +: 8] = 8'hAA;
         else for (int q = 0; q < 2; q++)
            s[8*h + 4*q +: 4] = ($urandom % 2 == 0) ? 4'h5 : 4'h0;
      end
      return s;
   endfunction

   task automatic t_round_trip_r8();
      for (int t = 0; t < 24; t++) begin
         logic [15:0] sz = rand_layout();
         logic [63:0] d = {$urandom, $urandom};
         logic [63:0] once;
         apply(d, sz, 1'b1, 1'b1);
         once = out_data;
         check(once == model(d, sz, 1'b1), "R8", "first pass", once, model(d, sz, 1'b1));
         apply(once, sz, 1'b1, 1'b1);
         check(out_data == d, "R8", "round trip", out_data, d);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset_r1();
      t_swap_off_r3();
      t_uniform_r4();
      t_mixed_r5();
      t_illegal_r6_r7();
      t_hold_r9_r2();
      t_round_trip_r8();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
      end
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule